// File: doc/BRIEF.md
# Cascaded Layer Time-Multiplexing Link

This block models a vertical chain of identical layer interface cells. All cells share one downward data path of full word width. Once per base period, every layer hands one word to its cell. Each cell forwards that word toward the bottom of the chain, followed by the words that arrive from the cells above it. The bottom cell therefore emits one full-width word from every layer in each base period. The words appear in fixed layer order on a single aggregate output.

All cells run on one fast clock whose rate is `NUM_LAYERS` times the base rate. A shared divider keeps the slot count inside the period and produces a clock enable for each cell. Cell `k` is enabled for the first `NUM_LAYERS-k` slots of every period. Cells higher in the chain therefore toggle less often, and the bottom cell runs every fast cycle. Each cell holds only a small local counter, a two-way multiplexer that picks its own word or the word from above, and one link register. The cells differ only in their position parameter.

Top module: `layer_cascade_link`

## Requirements
- R1: While `rst_ni` is low, `agg_valid_o` and `agg_data_o` are zero and `period_start_o` is high.
- R2: `period_start_o` is high for one cycle out of every `NUM_LAYERS` cycles. It is high in the first cycle after reset is released.
- R3: Layer `k`'s word is taken from `lay_data_i[k*WORD_W +: WORD_W]` and its valid bit from `lay_valid_i[k]`. Both are sampled at the rising edge where `period_start_o` is high.
- R4: After the sampling edge, the next `NUM_LAYERS` cycles present the words of layer 0, layer 1, and so on up to layer `NUM_LAYERS-1`, one per cycle. The word of layer `j` is on `agg_data_o` in the cycle that follows the `j`-th edge after sampling, counting the sampling edge as edge 0.
- R5: `agg_valid_o` in layer `j`'s slot equals the valid bit sampled for layer `j`, and no other layer's valid bit affects that slot.
- R6: Changes on `lay_data_i` and `lay_valid_i` at edges where `period_start_o` is low do not affect the aggregate output.
- R7: Every slot carries all `WORD_W` bits of its layer's word, so a word of all ones reaches the output intact.
- R8: Back-to-back periods follow each other with no idle cycle, and the latency from sampling to the first word is one cycle in every period.
- R9: Cell `k` is enabled only during slots 0 to `NUM_LAYERS-k-1`. While enabled, its local counter equals the current slot. It selects its own word only in slot 0.
- R10: An asynchronous reset in the middle of a period clears the output valid at once. The first period after release again starts with layer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, NUM_LAYERS times the base rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lay_data_i | input | NUM_LAYERS*WORD_W | One word per layer, layer k at bits k*WORD_W upward |
| lay_valid_i | input | NUM_LAYERS | Valid bit per layer |
| period_start_o | output | 1 | High in the slot whose closing edge samples the layer inputs |
| agg_data_o | output | WORD_W | Aggregate stream at the bottom of the chain |
| agg_valid_o | output | 1 | Valid flag travelling with agg_data_o |

## Verification
The assertions check the following on every cycle. The period strobe keeps its spacing. Each cell's enable window and local counter stay aligned with the shared slot. The bottom slot delivers layer 0's word and valid one cycle after sampling. The output stays quiet during reset. Only the bench scenarios can show the complete ordering of all layers across the period. They also show that inputs changed mid-period are ignored, that full-width patterns survive, that back-to-back periods keep the same latency, and that the chain recovers cleanly after a reset in mid-period.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slot_divider.sv
module slot_divider #(
  parameter int NUM_LAYERS = 4,
  parameter int SLOT_W     = cascade_pkg::cnt_width(NUM_LAYERS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [SLOT_W-1:0]     slot_o,
  output logic [NUM_LAYERS-1:0] en_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_LAYERS - 1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  // cell k is active for the first NUM_LAYERS-k slots of each period
  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_en
    assign en_o[k] = {1'b0, slot_q} < (SLOT_W+1)'(NUM_LAYERS - k);
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/cascade_cell.sv
module cascade_cell #(
  parameter int NUM_LAYERS = 4,
  parameter int WORD_W     = 16,
  parameter int POS        = 0,
  parameter int SLOT_W     = cascade_pkg::cnt_width(NUM_LAYERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] own_data_i,
  input  logic              own_vld_i,
  input  logic [WORD_W-1:0] up_data_i,
  input  logic              up_vld_i,
  output logic [WORD_W-1:0] dn_data_o,
  output logic              dn_vld_o,
  output logic [SLOT_W-1:0] cnt_o
);
  localparam int                SPAN = NUM_LAYERS - POS;
  localparam logic [SLOT_W-1:0] WRAP = SLOT_W'(SPAN - 1);

  logic [SLOT_W-1:0] cnt_q;
  logic [WORD_W-1:0] data_q;
  logic              vld_q;
  logic              sel_own;

  assign sel_own = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else if (en_i) begin
      cnt_q  <= (cnt_q == WRAP) ? '0 : cnt_q + 1'b1;
      data_q <= sel_own ? own_data_i : up_data_i;
      vld_q  <= sel_own ? own_vld_i  : up_vld_i;
    end
  end

  assign dn_data_o = data_q;
  assign dn_vld_o  = vld_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/layer_cascade_link.sv
module layer_cascade_link #(
  parameter int NUM_LAYERS = 4,
  parameter int WORD_W     = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_LAYERS*WORD_W-1:0] lay_data_i,
  input  logic [NUM_LAYERS-1:0]        lay_valid_i,
  output logic                         period_start_o,
  output logic [WORD_W-1:0]            agg_data_o,
  output logic                         agg_valid_o
);
  localparam int SLOT_W = cascade_pkg::cnt_width(NUM_LAYERS);

  logic [SLOT_W-1:0]            slot_q;
  logic [NUM_LAYERS-1:0]        cell_en;
  logic [NUM_LAYERS*SLOT_W-1:0] cell_cnt;
  logic [WORD_W-1:0]            link_data [NUM_LAYERS+1];
  logic                         link_vld  [NUM_LAYERS+1];

  slot_divider #(.NUM_LAYERS(NUM_LAYERS), .SLOT_W(SLOT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot_q),
    .en_o   (cell_en)
  );

  // nothing arrives from above the top layer
  assign link_data[NUM_LAYERS] = '0;
  assign link_vld[NUM_LAYERS]  = 1'b0;

  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_cell
    cascade_cell #(
      .NUM_LAYERS(NUM_LAYERS), .WORD_W(WORD_W), .POS(k), .SLOT_W(SLOT_W)
    ) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cell_en[k]),
      .own_data_i (lay_data_i[k*WORD_W +: WORD_W]),
      .own_vld_i  (lay_valid_i[k]),
      .up_data_i  (link_data[k+1]),
      .up_vld_i   (link_vld[k+1]),
      .dn_data_o  (link_data[k]),
      .dn_vld_o   (link_vld[k]),
      .cnt_o      (cell_cnt[k*SLOT_W +: SLOT_W])
    );
  end

  assign period_start_o = (slot_q == '0);
  assign agg_data_o     = link_data[0];
  assign agg_valid_o    = link_vld[0];
endmodule

// File: rtl/cascade_link_checker.sv
module cascade_link_checker #(
  parameter int NUM_LAYERS = 4,
  parameter int WORD_W     = 16,
  parameter int SLOT_W     = cascade_pkg::cnt_width(NUM_LAYERS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_LAYERS*WORD_W-1:0] lay_data_i,
  input logic [NUM_LAYERS-1:0]        lay_valid_i,
  input logic                         period_start_o,
  input logic [WORD_W-1:0]            agg_data_o,
  input logic                         agg_valid_o,
  input logic [SLOT_W-1:0]            slot_q,
  input logic [NUM_LAYERS-1:0]        cell_en,
  input logic [NUM_LAYERS*SLOT_W-1:0] cell_cnt
);
  logic [SLOT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                gap_q <= '0;
    else if (gap_q == SLOT_W'(NUM_LAYERS - 1))  gap_q <= '0;
    else                                        gap_q <= gap_q + 1'b1;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (!agg_valid_o && agg_data_o == '0 && period_start_o));

  a_r2_strobe_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o == (gap_q == '0));

  a_r4_layer0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_o && lay_valid_i[0]) |=>
      (agg_valid_o && agg_data_o == $past(lay_data_i[WORD_W-1:0])));

  a_r5_invalid_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_o && !lay_valid_i[0]) |=> !agg_valid_o);

  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_cell_chk
    a_r9_cnt_tracks_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cell_en[k] |-> (cell_cnt[k*SLOT_W +: SLOT_W] == slot_q));
    a_r9_idle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cell_en[k] |-> ({1'b0, slot_q} >= (SLOT_W+1)'(NUM_LAYERS - k)));
  end
endmodule

bind layer_cascade_link cascade_link_checker #(
  .NUM_LAYERS(NUM_LAYERS), .WORD_W(WORD_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lay_data_i     (lay_data_i),
  .lay_valid_i    (lay_valid_i),
  .period_start_o (period_start_o),
  .agg_data_o     (agg_data_o),
  .agg_valid_o    (agg_valid_o),
  .slot_q         (slot_q),
  .cell_en        (cell_en),
  .cell_cnt       (cell_cnt)
);

// File: tb/layer_cascade_link_tb.sv
module layer_cascade_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;
  localparam int W = 16;
  localparam int NVEC = 6;
  // {valid mask, base word}
  localparam logic [L+W-1:0] VEC [NVEC] = '{
    {4'b1111, 16'h1234}, {4'b1111, 16'hFFFF}, {4'b0101, 16'hA5A5},
    {4'b1010, 16'h0F0F}, {4'b1111, 16'h0000}, {4'b1111, 16'h8001}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [L*W-1:0] lay_data_i = '0;
  logic [L-1:0] lay_valid_i = '0;
  logic period_start_o;
  logic [W-1:0] agg_data_o;
  logic agg_valid_o;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  layer_cascade_link #(.NUM_LAYERS(L), .WORD_W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lay_data_i(lay_data_i),
    .lay_valid_i(lay_valid_i), .period_start_o(period_start_o),
    .agg_data_o(agg_data_o), .agg_valid_o(agg_valid_o)
  );

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] base, input int k);
    return base ^ (W'(k) * 16'h1111);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // entered at a negedge with period_start_o high; leaves at the next such negedge
  task automatic run_period(input logic [L-1:0] mask, input logic [W-1:0] base);
    for (int k = 0; k < L; k++) lay_data_i[k*W +: W] = exp_word(base, k);
    lay_valid_i = mask;
    @(posedge clk_i);  // R3 sampling edge
    for (int j = 0; j < L; j++) begin
      @(negedge clk_i);
      if (j == 0) begin  // R6 junk after sampling
        lay_data_i  = ~lay_data_i;
        lay_valid_i = ~mask;
      end
      check(agg_valid_o == mask[j], "R5 valid per slot", 32'(agg_valid_o), 32'(mask[j]));
      if (mask[j])
        check(agg_data_o == exp_word(base, j), "R3/R4/R6/R7/R9 slot word",
              32'(agg_data_o), 32'(exp_word(base, j)));
      check(period_start_o == (j == L-1), "R2/R8 strobe spacing",
            32'(period_start_o), 32'(j == L-1));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(!agg_valid_o, "R1 valid in reset", 32'(agg_valid_o), 0);
    check(agg_data_o == '0, "R1 data in reset", 32'(agg_data_o), 0);
    check(period_start_o, "R1 strobe in reset", 32'(period_start_o), 1);
    rst_ni = 1'b1;
    check(period_start_o, "R2 first strobe after release", 32'(period_start_o), 1);

    // R8: vectors walked back to back
    for (int v = 0; v < NVEC; v++) run_period(VEC[v][L+W-1:W], VEC[v][W-1:0]);

    // R10: reset in mid period
    for (int k = 0; k < L; k++) lay_data_i[k*W +: W] = exp_word(16'h5A5A, k);
    lay_valid_i = '1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(agg_valid_o && agg_data_o == exp_word(16'h5A5A, 0), "R10 pre-reset word",
          32'(agg_data_o), 32'(exp_word(16'h5A5A, 0)));
    rst_ni = 1'b0;
    #1;
    check(!agg_valid_o, "R10 valid cleared", 32'(agg_valid_o), 0);
    check(period_start_o, "R10 slot back to start", 32'(period_start_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_period(4'b1111, 16'hC3C3);
    run_period(4'b0110, 16'h7E7E);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule